// File: doc/BRIEF.md
# On-Chip ROM Access Sequencer

This block connects a processor-side read request to a compiled on-chip ROM that is built from two separately enabled 16-bit halves. It accepts one request at a time. A request is a single byte, halfword or longword read, or a line read of four longwords. The block drives a longword address to the ROM and two active-low half enables. It captures the returned data one clock later and hands each beat back with a one-cycle valid pulse. A done pulse closes every request.

The total ROM size is given as a 3-bit code. It sets which address bits may toggle. Every address bit above the valid range is held low. A size code of zero means no ROM is fitted. A request in that case finishes at once with an error flag, and no enable is ever asserted. A line read starts at the requested longword and wraps inside its 16-byte line, so 128 bits cross the 32-bit path in four consecutive beats.

Top module: `romAccessSeq`

## Requirements
- R1: A request (reqValid high) is taken only when the block is not busy. busy goes high in the cycle after acceptance and stays high until the cycle that carries the last rdValid beat, inclusive.
- R2: romAddr carries byte-address bits 14:2 of the current beat (romAddr[0] is byte bit 2). The number of valid bits follows romSizeCode: code c in 1..7 (512 B, 1 KB, 2 KB, 4 KB, 8 KB, 16 KB, 32 KB) keeps romAddr[c+5:0], and every bit above that is driven low.
- R3: romEnN is active low. romEnN[0] selects the half that returns data bits 31:16, and romEnN[1] selects the half that returns bits 15:0. reqSize encodes 0 = byte, 1 = halfword, 2 = longword, 3 = line. A longword or line beat drives 2'b00. A byte or halfword access drives only one enable: request address bit 1 = 0 gives 2'b10, and 1 gives 2'b01. Outside an active beat romEnN is 2'b11.
- R4: A line read presents exactly four beats on consecutive cycles. It starts at the requested longword, and romAddr[1:0] increments by one each beat modulo 4, while the upper address bits stay fixed.
- R5: Data on romData is captured at the clock edge that ends the cycle in which its address is presented, and it appears on rdData together with a one-cycle rdValid pulse. Byte lanes are big-endian: byte offset 0 is bits 31:24. Lanes outside the requested byte or halfword read as zero.
- R6: done pulses for one cycle in the cycle right after the last rdValid beat.
- R7: With romSizeCode = 0, romEnN stays 2'b11. A request then gives done and err high together in the cycle after acceptance, with no rdValid beat and busy staying low.
- R8: After reset, busy, rdValid, done and err are low and romEnN is 2'b11.
- R9: A request raised while busy is ignored. The running transfer's beats are unchanged, and no extra transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 15 | Byte address of the request |
| reqSize | input | 2 | Transfer size: 0 byte, 1 half, 2 longword, 3 line |
| romSizeCode | input | 3 | Fitted ROM size code, 0 = none, 1..7 = 512 B..32 KB |
| romAddr | output | 13 | Longword address to the ROM |
| romEnN | output | 2 | Active-low half enables ([0] upper half, [1] lower half) |
| romData | input | 32 | Read data from the two ROM halves |
| rdData | output | 32 | Captured, lane-masked read data |
| rdValid | output | 1 | One pulse per returned beat |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Request complete pulse |
| err | output | 1 | Request rejected because no ROM is fitted |

## Verification
On every cycle the assertions check several rules. Enables are only active while busy. Narrow beats drive exactly one enable. Consecutive line beats step the low address bits by one. Each rdValid follows a cycle with an active enable. done comes with the fall of busy, and err always comes with done. The actual data values, the address masking for each ROM size, the lane zeroing and the exact cycle counts of each request can only be shown by the bench's sweep. It runs every size code against every transfer size and several start offsets, with a behavioural ROM model and expected words computed from the address arithmetic. Ignoring a request made while busy is also shown only by a directed scenario.

// File: rtl/romSeqPkg.sv
package romSeqPkg;

  typedef enum logic [1:0] {
    XFER_BYTE = 2'd0,
    XFER_HALF = 2'd1,
    XFER_WORD = 2'd2,
    XFER_LINE = 2'd3
  } xferSize_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_LAST,
    ST_FIN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new request
    logic step;     // advance to the next line beat
    logic present;  // drive address and enables this cycle
  } seqStrobe_t;

endpackage

// File: rtl/romSeqCtrl.sv
module romSeqCtrl
  import romSeqPkg::*;
#(
  parameter int LINE_BEATS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  xferSize_t  reqSize,
  input  logic       romOff,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       err
);

  localparam int BEAT_W = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST_LINE_BEAT = BEAT_W'(LINE_BEATS - 1);

  seqState_t         state;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] lastBeat;
  logic              canAccept;
  logic              accept;

  assign canAccept = (state == ST_IDLE) || (state == ST_FIN);
  assign accept    = reqValid && canAccept;
  assign busy      = (state == ST_RUN) || (state == ST_LAST);

  always_comb begin
    strobe         = '0;
    strobe.load    = accept && !romOff;
    strobe.present = (state == ST_RUN);
    strobe.step    = (state == ST_RUN) && (beatCnt != lastBeat);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      beatCnt  <= '0;
      lastBeat <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE, ST_FIN: begin
          if (accept) begin
            if (romOff) begin
              state <= ST_FIN;
              done  <= 1'b1;
              err   <= 1'b1;
            end else begin
              state    <= ST_RUN;
              beatCnt  <= '0;
              lastBeat <= (reqSize == XFER_LINE) ? LAST_LINE_BEAT : '0;
            end
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_RUN: begin
          if (beatCnt == lastBeat) state <= ST_LAST;
          else beatCnt <= beatCnt + 1'b1;
        end
        ST_LAST: begin
          state <= ST_FIN;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  done_on_busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (done && !busy));

  // R1
  busy_from_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

endmodule

// File: rtl/romSeqDatapath.sv
module romSeqDatapath
  import romSeqPkg::*;
#(
  parameter int BYTE_ADDR_W   = 15,
  parameter int SIZE_CODE_W   = 3,
  parameter int MIN_VALID_TOP = 8,
  parameter int LINE_BEATS    = 4,
  parameter int DATA_W        = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strobe,
  input  logic [BYTE_ADDR_W-1:0] reqAddr,
  input  xferSize_t              reqSize,
  input  logic [SIZE_CODE_W-1:0] romSizeCode,
  input  logic [DATA_W-1:0]      romData,
  output logic [BYTE_ADDR_W-3:0] romAddr,
  output logic [1:0]             romEnN,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdValid
);

  localparam int WADDR_W = BYTE_ADDR_W - 2;
  localparam int WRAP_W  = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;
  localparam int LANES   = DATA_W / 8;

  logic [WADDR_W-1:0]     wordPtr;
  logic [1:0]             offQ;
  xferSize_t              sizeQ;
  logic [SIZE_CODE_W-1:0] codeQ;
  logic [WADDR_W-1:0]     addrMask;
  logic [LANES-1:0]       laneMask;
  logic [DATA_W-1:0]      maskedData;
  logic                   wide;

  // address bits allowed by the fitted ROM size
  for (genvar i = 0; i < WADDR_W; i++) begin : g_mask
    assign addrMask[i] = (codeQ != '0) && (i < int'(codeQ) + MIN_VALID_TOP - 2);
  end

  assign wide    = (sizeQ == XFER_WORD) || (sizeQ == XFER_LINE);
  assign romAddr = strobe.present ? (wordPtr & addrMask) : '0;

  always_comb begin
    if (!strobe.present) romEnN = 2'b11;
    else if (wide)       romEnN = 2'b00;
    else if (offQ[1])    romEnN = 2'b01;
    else                 romEnN = 2'b10;
  end

  // lane LANES-1 holds byte offset 0 (big-endian)
  always_comb begin
    unique case (sizeQ)
      XFER_BYTE: laneMask = LANES'(4'b1000 >> offQ);
      XFER_HALF: laneMask = offQ[1] ? LANES'(4'b0011) : LANES'(4'b1100);
      default:   laneMask = '1;
    endcase
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign maskedData[8*b +: 8] = laneMask[b] ? romData[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordPtr <= '0;
      offQ    <= '0;
      sizeQ   <= XFER_BYTE;
      codeQ   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.present;
      if (strobe.present) rdData <= maskedData;
      if (strobe.load) begin
        wordPtr <= reqAddr[BYTE_ADDR_W-1:2];
        offQ    <= reqAddr[1:0];
        sizeQ   <= reqSize;
        codeQ   <= romSizeCode;
      end else if (strobe.step) begin
        wordPtr[WRAP_W-1:0] <= wordPtr[WRAP_W-1:0] + 1'b1;
      end
    end
  end

  // R3
  narrow_one_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.present && !wide) |-> ($countones(romEnN) == 1));

  // R4
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.present && $past(strobe.present) && sizeQ == XFER_LINE)
      |-> (romAddr[WRAP_W-1:0] == $past(romAddr[WRAP_W-1:0]) + 1'b1));

  // R5
  valid_after_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(romEnN) != 2'b11));

endmodule

// File: rtl/romAccessSeq.sv
module romAccessSeq
  import romSeqPkg::*;
#(
  parameter int BYTE_ADDR_W   = 15,
  parameter int SIZE_CODE_W   = 3,
  parameter int MIN_VALID_TOP = 8,
  parameter int LINE_BEATS    = 4,
  parameter int DATA_W        = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [BYTE_ADDR_W-1:0] reqAddr,
  input  logic [1:0]             reqSize,
  input  logic [SIZE_CODE_W-1:0] romSizeCode,
  output logic [BYTE_ADDR_W-3:0] romAddr,
  output logic [1:0]             romEnN,
  input  logic [DATA_W-1:0]      romData,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdValid,
  output logic                   busy,
  output logic                   done,
  output logic                   err
);

  seqStrobe_t strobe;
  xferSize_t  sizeIn;

  assign sizeIn = xferSize_t'(reqSize);

  romSeqCtrl #(.LINE_BEATS(LINE_BEATS)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqSize (sizeIn),
    .romOff  (romSizeCode == '0),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done),
    .err     (err)
  );

  romSeqDatapath #(
    .BYTE_ADDR_W  (BYTE_ADDR_W),
    .SIZE_CODE_W  (SIZE_CODE_W),
    .MIN_VALID_TOP(MIN_VALID_TOP),
    .LINE_BEATS   (LINE_BEATS),
    .DATA_W       (DATA_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqSize    (sizeIn),
    .romSizeCode(romSizeCode),
    .romData    (romData),
    .romAddr    (romAddr),
    .romEnN     (romEnN),
    .rdData     (rdData),
    .rdValid    (rdValid)
  );

  // R1
  enable_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (romEnN != 2'b11) |-> busy);

endmodule

// File: tb/test_romAccessSeq.sv
module test_romAccessSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [2:0]  romSizeCode = '0;
  logic [12:0] romAddr;
  logic [1:0]  romEnN;
  logic [31:0] romData;
  logic [31:0] rdData;
  logic        rdValid, busy, done, err;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  romAccessSeq i_romAccessSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .romSizeCode(romSizeCode), .romAddr(romAddr),
    .romEnN(romEnN), .romData(romData), .rdData(rdData), .rdValid(rdValid),
    .busy(busy), .done(done), .err(err)
  );

  function automatic logic [31:0] romWord(input logic [12:0] a);
    return ({19'd0, a} * 32'h9E3779B1) ^ 32'h0F1E2D3C;
  endfunction

  // behavioural ROM: asynchronous read, unselected half returns junk
  always_comb begin
    logic [31:0] w;
    w = romWord(romAddr);
    romData = {romEnN[0] ? 16'hDEAD : w[31:16], romEnN[1] ? 16'hBEEF : w[15:0]};
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expBeat(input logic [14:0] a, input logic [1:0] sz,
                                          input logic [2:0] code, input int i);
    logic [12:0] w;
    logic [12:0] m;
    logic [31:0] d;
    logic [3:0]  lanes;
    w = a[14:2];
    if (sz == 2'd3) w[1:0] = w[1:0] + 2'(i);
    m = (code == 0) ? 13'd0 : 13'((32'd1 << (code + 6)) - 1);
    d = romWord(w & m);
    case (sz)
      2'd0: lanes = 4'b1000 >> a[1:0];
      2'd1: lanes = a[1] ? 4'b0011 : 4'b1100;
      default: lanes = 4'b1111;
    endcase
    for (int b = 0; b < 4; b++) if (!lanes[b]) d[8*b +: 8] = 8'h00;
    return d;
  endfunction

  task automatic runReq(input logic [14:0] a, input logic [1:0] sz,
                        input logic [2:0] code, input bit intrude);
    int beats, doneAt, seen, dones;
    logic [1:0] expEn;
    beats  = (code == 0) ? 0 : ((sz == 2'd3) ? 4 : 1);
    doneAt = (code == 0) ? 1 : beats + 2;
    expEn  = (sz >= 2'd2) ? 2'b00 : (a[1] ? 2'b01 : 2'b10);
    seen = 0; dones = 0;
    @(negedge clk);
    romSizeCode = code; reqAddr = a; reqSize = sz; reqValid = 1'b1;
    for (int n = 1; n <= beats + 5; n++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (intrude && n == 2) begin
        reqValid = 1'b1; reqAddr = a ^ 15'h7FFC; reqSize = 2'd0;
      end
      // R1 busy window
      chk(busy == (code != 0 && n <= beats + 1), "R1 busy", 32'(busy),
          32'(code != 0 && n <= beats + 1));
      if (n <= beats) chk(romEnN == expEn, "R3 enables", 32'(romEnN), 32'(expEn));
      else chk(romEnN == 2'b11, (code == 0) ? "R7 enables off" : "R3 enables idle",
               32'(romEnN), 32'h3);
      if (rdValid) begin
        chk(n == seen + 2, "R5 beat timing", 32'(n), 32'(seen + 2));
        chk(rdData == expBeat(a, sz, code, seen),
            (sz == 2'd3) ? "R4 line beat" : ((code < 7) ? "R2 masked data" : "R5 data"),
            rdData, expBeat(a, sz, code, seen));
        seen++;
      end
      if (done) begin
        dones++;
        chk(n == doneAt, "R6 done timing", 32'(n), 32'(doneAt));
        chk(err == (code == 0), "R7 err flag", 32'(err), 32'(code == 0));
      end
    end
    chk(seen == beats, intrude ? "R9 beat count" : "R4 beat count", 32'(seen), 32'(beats));
    chk(dones == 1, "R6 single done", 32'(dones), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!busy && !rdValid && !done && !err && romEnN == 2'b11, "R8 reset",
        {busy, rdValid, done, err, 26'd0, romEnN}, 32'h3);
    rstN = 1'b1;
    for (int code = 0; code < 8; code++)
      for (int sz = 0; sz < 4; sz++)
        for (int base = 0; base < 3; base++)
          for (int off = 0; off < 4; off++)
            runReq(((base == 0) ? 15'h7FF0 : (base == 1) ? 15'h0124 : 15'h5A38) | 15'(off),
                   2'(sz), 3'(code), 1'b0);
    // R9 request while busy is ignored
    runReq(15'h1238, 2'd3, 3'd7, 1'b1);
    runReq(15'h6E46, 2'd1, 3'd5, 1'b1);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule